// File: doc/BRIEF.md
# Source-Sampled Word Crossing

This block moves a multi-bit word from a fast source clock domain into a much slower destination clock domain. It uses neither Gray coding nor a request/acknowledge handshake. The source domain treats the destination clock as an ordinary data input. It passes that clock through a short flip-flop chain and detects its rising edge, which yields a one-cycle sample enable shortly after every destination rising edge.

On the enable cycle, a holding register in the source domain takes the current source word. The holding register then stays unchanged for nearly a whole destination period. The destination domain samples it with one flip-flop per bit at its next rising edge. Because every bit has been settled for a long time when it is sampled, the word arrives coherent.

The block is meant for slow timer, configuration or status words that a fast bus domain publishes to a slow, low-rate domain. The destination clock must be many source periods long.

Top module: `swx_top`

## Requirements
- R1: While `rstN` is low, the holding register and `dstData` are all zeros. After reset is released, `dstData` stays zero until a word loaded after the release has been captured.
- R2: Take a destination rising edge while out of reset. Count the source rising edges that follow it as 1, 2, 3 and so on. The word present on `srcData` at source edge number `SYNC_STAGES+1` appears on `dstData` at the next destination rising edge.
- R3: Values that `srcData` carries at any other source edge of a destination period have no effect on `dstData`.
- R4: `dstData` changes only at destination rising edges and holds its value between them.
- R5: Each of the `DATA_W` bits is carried independently. A single set bit at any position arrives at that same position, and the complemented word never leaks into it.
- R6: The block issues exactly one single-cycle sample enable per destination rising edge. Consecutive enables are at least several source cycles apart, given the required slow destination clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| srcClk | input | 1 | Fast source clock |
| dstClk | input | 1 | Slow destination clock, also sampled as data in the source domain |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| srcData | input | DATA_W | Word offered by the source domain |
| dstData | output | DATA_W | Word as captured in the destination domain |

## Verification
The bench builds the block with `DATA_W` = 12 and `SYNC_STAGES` = 3. With three stages, the load point moves to the fourth source edge after a destination edge, so an off-by-one in the chain or the edge detect would load the wrong word. The destination period is 16.5 source periods. Destination edges therefore fall alternately at two different phases inside a source cycle, which covers both ways the synchronizer can first see the rising level. A random word on every source cycle, and a word whose complement is driven on all non-load edges, expose any leak of off-load data into `dstData`.

// File: rtl/swx_pkg.sv
`timescale 1ns/1ps
package swx_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic sampleEn;   // one source cycle, just after a destination rising edge
  } swxStb_t;

endpackage

// File: rtl/swx_ctrl.sv
`timescale 1ns/1ps
module swx_ctrl
  import swx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    srcClk,
  input  logic    rstN,
  input  logic    dstClk,
  output swxStb_t stb
);

  localparam int LAST = SYNC_STAGES - 1;

  // The destination clock is sampled as a level in the source domain.
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lastLevel;

  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) begin
      syncQ     <= '0;
      lastLevel <= 1'b0;
    end else begin
      syncQ[0] <= dstClk;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        syncQ[i] <= syncQ[i-1];
      end
      lastLevel <= syncQ[LAST];
    end
  end

  // Rising-edge detect on the retimed level gives one enable cycle.
  always_comb begin
    stb          = '0;
    stb.sampleEn = syncQ[LAST] & ~lastLevel;
  end

endmodule

// File: rtl/swx_path.sv
`timescale 1ns/1ps
module swx_path
  import swx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              srcClk,
  input  logic              dstClk,
  input  logic              rstN,
  input  swxStb_t           stb,
  input  logic [DATA_W-1:0] srcData,
  output logic [DATA_W-1:0] holdWord,
  output logic [DATA_W-1:0] dstData
);

  // Source side: loads only on the enable cycle.
  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) begin
      holdWord <= '0;
    end else if (stb.sampleEn) begin
      holdWord <= srcData;
    end
  end

  // Destination side: one flop per bit, fed straight from the holding register.
  for (genvar g = 0; g < DATA_W; g++) begin : g_capture
    always_ff @(posedge dstClk or negedge rstN) begin
      if (!rstN) begin
        dstData[g] <= 1'b0;
      end else begin
        dstData[g] <= holdWord[g];
      end
    end
  end

endmodule

// File: rtl/swx_top.sv
`timescale 1ns/1ps
module swx_top
  import swx_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              srcClk,
  input  logic              dstClk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] srcData,
  output logic [DATA_W-1:0] dstData
);

  swxStb_t           ctrlStb;
  logic [DATA_W-1:0] holdWord;

  swx_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .srcClk(srcClk),
    .rstN  (rstN),
    .dstClk(dstClk),
    .stb   (ctrlStb)
  );

  swx_path #(
    .DATA_W(DATA_W)
  ) u_path (
    .srcClk  (srcClk),
    .dstClk  (dstClk),
    .rstN    (rstN),
    .stb     (ctrlStb),
    .srcData (srcData),
    .holdWord(holdWord),
    .dstData (dstData)
  );

endmodule

// File: rtl/swx_checks.sv
`timescale 1ns/1ps
module swx_checks
  import swx_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int MIN_GAP = 8
) (
  input logic              srcClk,
  input logic              dstClk,
  input logic              rstN,
  input swxStb_t           stb,
  input logic [DATA_W-1:0] holdWord,
  input logic [DATA_W-1:0] dstData
);

  localparam int GAP_W = $clog2(MIN_GAP + 1) + 1;
  localparam logic [GAP_W-1:0] GAP_MAX = '1;

  // Source cycles since the previous enable, saturating.
  logic [GAP_W-1:0] gap;
  logic             seenEn;

  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) begin
      gap    <= '0;
      seenEn <= 1'b0;
    end else if (stb.sampleEn) begin
      gap    <= GAP_W'(1);
      seenEn <= 1'b1;
    end else if (gap != GAP_MAX) begin
      gap <= gap + 1'b1;
    end
  end

  // R1: reset clears the source-side holding register
  a_r1_hold_reset: assert property (@(posedge srcClk) !rstN |-> holdWord == '0);

  // R1: reset clears the destination word
  a_r1_dst_reset: assert property (@(posedge dstClk) !rstN |-> dstData == '0);

  // R6: the enable lasts a single source cycle
  a_r6_single_pulse: assert property (@(posedge srcClk) disable iff (!rstN)
    stb.sampleEn |=> !stb.sampleEn);

  // R6: enables are spread out by the slow destination period
  a_r6_pulse_gap: assert property (@(posedge srcClk) disable iff (!rstN)
    (stb.sampleEn && seenEn) |-> gap >= GAP_W'(MIN_GAP));

  // R3: the holding register moves only after an enable cycle
  a_r3_hold_stable: assert property (@(posedge srcClk) disable iff (!rstN)
    !stb.sampleEn |=> $stable(holdWord));

endmodule

bind swx_top swx_checks #(
  .DATA_W(DATA_W)
) u_swxChecks (
  .srcClk  (srcClk),
  .dstClk  (dstClk),
  .rstN    (rstN),
  .stb     (ctrlStb),
  .holdWord(holdWord),
  .dstData (dstData)
);

// File: tb/test_swx_top.sv
`timescale 1ns/1ps
module test_swx_top;

  localparam int  DATA_W      = 12;
  localparam int  SYNC_STAGES = 3;
  localparam int  LOAD_EDGE   = SYNC_STAGES + 1;
  localparam time SRC_HALF    = 10ns;    // 50 MHz
  localparam time DST_HALF    = 165ns;   // 16.5 source periods

  logic              srcClk = 1'b0;
  logic              dstClk = 1'b0;
  logic              rstN   = 1'b0;
  logic [DATA_W-1:0] srcData = '0;
  logic [DATA_W-1:0] dstData;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // Bench model state
  int                srcEdgeCount = 99;
  logic [DATA_W-1:0] expHold = '0;
  logic [DATA_W-1:0] expDst  = '0;
  int                mode    = 0;       // 0 random, 1 pattern on load edge only
  logic [DATA_W-1:0] pattern = '0;
  bit                checking = 1'b0;
  string             tag = "R2";

  swx_top #(
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_swx_top (
    .srcClk (srcClk),
    .dstClk (dstClk),
    .rstN   (rstN),
    .srcData(srcData),
    .dstData(dstData)
  );

  initial forever #SRC_HALF srcClk = ~srcClk;
  initial forever #DST_HALF dstClk = ~dstClk;

  task automatic check(input bit ok, input string req,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Model: the word at source edge LOAD_EDGE after a destination rise is held.
  always @(posedge srcClk) begin
    if (!rstN) begin
      srcEdgeCount = 99;
      expHold      = '0;
    end else begin
      if (srcEdgeCount < 99) srcEdgeCount++;
      if (srcEdgeCount == LOAD_EDGE) expHold = srcData;
    end
  end

  always @(posedge dstClk) begin
    if (!rstN) begin
      expDst = '0;
    end else begin
      expDst       = expHold;
      srcEdgeCount = 0;
    end
  end

  always @(negedge rstN) begin
    expDst       = '0;
    expHold      = '0;
    srcEdgeCount = 99;
  end

  // Stimulus: changes on source falling edges.
  initial begin
    void'($urandom(32'h5EED_0C1C));
    forever begin
      @(negedge srcClk);
      if (mode == 0) srcData = DATA_W'($urandom);
      else srcData = (srcEdgeCount + 1 == LOAD_EDGE) ? pattern : ~pattern;
    end
  end

  // R4: compare on every source falling edge, which never meets a destination edge.
  initial forever begin
    @(negedge srcClk);
    if (checking && rstN) begin
      check(dstData === expDst, {"R4 ", tag}, dstData, expDst);
    end
  end

  initial begin
    #5;
    check(dstData === '0, "R1 in reset", dstData, '0);
    repeat (3) @(negedge srcClk);
    rstN     = 1'b1;
    checking = 1'b1;

    // R2: random word every source cycle
    tag  = "R2 random";
    mode = 0;
    repeat (40) @(posedge dstClk);

    // R3: pattern only at the load edge, complement on all others
    tag  = "R3 off-load ignored";
    mode = 1;
    foreach (pattern[i]) pattern[i] = i[0];
    repeat (3) @(posedge dstClk);
    pattern = '1;
    repeat (3) @(posedge dstClk);
    pattern = '0;
    repeat (3) @(posedge dstClk);
    for (int k = 0; k < 6; k++) begin
      pattern = DATA_W'($urandom);
      repeat (2) @(posedge dstClk);
    end

    // R5: walking single bit
    tag = "R5 walking bit";
    for (int b = 0; b < DATA_W; b++) begin
      pattern = DATA_W'(1) << b;
      repeat (2) @(posedge dstClk);
    end

    // R1: reset in mid-run, while the destination clock is low
    @(negedge dstClk);
    @(negedge srcClk);
    checking = 1'b0;
    rstN     = 1'b0;
    #1;
    check(dstData === '0, "R1 mid-run reset", dstData, '0);
    repeat (4) @(negedge srcClk);
    check(dstData === '0, "R1 held in reset", dstData, '0);
    rstN     = 1'b1;
    checking = 1'b1;
    tag      = "R1 after release";
    @(posedge dstClk);
    #2;
    check(dstData === '0, "R1 first capture after release", dstData, '0);

    tag  = "R2 random again";
    mode = 0;
    repeat (40) @(posedge dstClk);
    @(negedge srcClk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule